// File: doc/BRIEF.md
# Packed Integer Add/Subtract Unit

This block adds or subtracts two wide operand vectors lane by lane. The lane size is picked per operation: bytes, halfwords, words or doublewords. One byte-sliced carry chain is cut at every lane start, so lanes never affect each other. Each lane result either wraps to the lane width or is clamped to the lane's signed or unsigned range.

Clamping is only allowed for byte and halfword lanes. If a clamping mode, or the reserved mode code, is requested with wider lanes, the unit flags the request and computes wrapping results. A single register stage holds the result. The output valid strobe trails the input valid strobe by one clock.

Top module: `simd_addsub_unit`

## Requirements
- R1: With `arithMode`=0 (wrap) and `opSub`=0, each lane of `result` is (A lane + B lane) mod 2^w. `laneSel` selects w: 0=8, 1=16, 2=32, 3=64 bits. Lane i occupies bits [i*w+w-1 : i*w].
- R2: With wrap mode and `opSub`=1, each lane is (A lane − B lane) mod 2^w. A is the minuend and B the subtrahend.
- R3: No carry or borrow passes from one lane into the next at any lane width.
- R4: With `arithMode`=1 (signed clamp) and w of 8 or 16, each lane holds the exact two's-complement sum or difference clamped to [−2^(w−1), 2^(w−1)−1].
- R5: With `arithMode`=2 (unsigned clamp), w of 8 or 16 and `opSub`=0, each lane holds min(A+B, 2^w−1).
- R6: With `arithMode`=2, w of 8 or 16 and `opSub`=1, each lane holds max(A−B, 0).
- R7: A nonzero `arithMode` with w of 32 or 64, or `arithMode`=3 at any width, sets `illegalOp` to 1 with the result and gives wrapping results. In every other case `illegalOp` is 0.
- R8: `outValid` equals `inValid` delayed by exactly one clock.
- R9: While `inValid` is 0, `result` and `illegalOp` keep their last values, whatever the other inputs do.
- R10: While the synchronous active-low reset `rstN` is 0, `outValid`, `illegalOp` and `result` are cleared at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and controls are valid this cycle |
| opSub | input | 1 | 1 = subtract (A − B), 0 = add |
| laneSel | input | 2 | Lane width: 0=8, 1=16, 2=32, 3=64 bits |
| arithMode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 reserved |
| opA | input | 256 | Operand A (minuend) |
| opB | input | 256 | Operand B (subtrahend) |
| outValid | output | 1 | Result valid, one clock after inValid |
| result | output | 256 | Registered lane results |
| illegalOp | output | 1 | Registered flag for a clamp request at an unsupported width |

## Verification
The assertions check these properties on every cycle:
- the one-clock valid delay;
- the illegal-width flag;
- the direction of byte-lane clamps: an unsigned add never falls below A, an unsigned subtract never exceeds A, and a signed add of two non-negative bytes stays non-negative.

Only the bench scenarios show that lane values are exact. This covers lane isolation at each width, the exact clamp limits, the fallback to wrapping and the holding of results while idle. The bench sweeps every byte pair in every mode and direction. At the wider lanes it uses pseudo-random vectors and the edge values at the signed maximum, signed minimum, all-ones and zero.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_H16 = 2'd1,
    LANE_W32 = 2'd2,
    LANE_D64 = 2'd3
  } laneWidthE;

  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_SSAT = 2'd1,
    MODE_USAT = 2'd2,
    MODE_RSVD = 2'd3
  } arithModeE;

  // Strobes passed from the decoder to the datapath.
  typedef struct packed {
    logic       load;
    logic       doSub;
    logic       satSigned;
    logic       satUnsigned;
    logic       illegal;
    logic [1:0] laneLog;   // log2 of lane width in bytes
  } ctrlStrobesT;

endpackage

// File: rtl/simd_addsub_ctrl.sv
module simd_addsub_ctrl
  import simd_addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        opSub,
  input  logic [1:0]  laneSel,
  input  logic [1:0]  arithMode,
  output ctrlStrobesT strobes,
  output logic        outValid
);

  laneWidthE laneW;
  arithModeE modeE;
  logic      narrowLane;
  logic      clampOk;

  always_comb begin
    laneW      = laneWidthE'(laneSel);
    modeE      = arithModeE'(arithMode);
    narrowLane = (laneW == LANE_B8) || (laneW == LANE_H16);
    clampOk    = narrowLane && (modeE != MODE_RSVD);

    strobes.load        = inValid;
    strobes.doSub       = opSub;
    strobes.laneLog     = laneSel;
    strobes.satSigned   = clampOk && (modeE == MODE_SSAT);
    strobes.satUnsigned = clampOk && (modeE == MODE_USAT);
    strobes.illegal     = (modeE != MODE_WRAP) && !clampOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8: valid output trails valid input by one clock
  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (outValid == $past(inValid)));

endmodule

// File: rtl/simd_addsub_dp.sv
module simd_addsub_dp
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] resultQ,
  output logic              illegalQ
);

  localparam int NSLICE = DATA_W / SLICE_W;

  logic [NSLICE-1:0]  carryOut;    // carry out of each slice MSB
  logic [NSLICE-1:0]  carryMsb;    // carry into each slice MSB
  logic [NSLICE-1:0]  sliceSign;   // sign bit of A per slice
  logic [DATA_W-1:0]  nextResult;

  genvar k;
  generate
    for (k = 0; k < NSLICE; k++) begin : g_slice
      localparam int TOP16 = k | 1;
      logic [SLICE_W-1:0] aS, bEff, sumS, satVal;
      logic [SLICE_W:0]   fullSum;
      logic [SLICE_W-1:0] lowSum;
      logic               laneStart, cin, isTop;
      logic               topCarry, topOvf, topSign, usatHit;

      assign aS   = a[k*SLICE_W +: SLICE_W];
      assign bEff = strobes.doSub ? ~b[k*SLICE_W +: SLICE_W] : b[k*SLICE_W +: SLICE_W];

      // a slice opens a lane when its index is a multiple of the lane size in slices
      assign laneStart = ((k & ((1 << strobes.laneLog) - 1)) == 0);
      if (k == 0) begin : g_first
        assign cin = strobes.doSub;
      end else begin : g_rest
        assign cin = laneStart ? strobes.doSub : carryOut[k-1];
      end

      assign fullSum = {1'b0, aS} + {1'b0, bEff} + {{SLICE_W{1'b0}}, cin};
      assign lowSum  = {1'b0, aS[SLICE_W-2:0]} + {1'b0, bEff[SLICE_W-2:0]}
                     + {{(SLICE_W-1){1'b0}}, cin};
      assign sumS         = fullSum[SLICE_W-1:0];
      assign carryOut[k]  = fullSum[SLICE_W];
      assign carryMsb[k]  = lowSum[SLICE_W-1];
      assign sliceSign[k] = aS[SLICE_W-1];

      // the top slice of the lane decides the clamp (clamps only at 8 or 16 bits)
      assign isTop    = (strobes.laneLog == 2'd0) || ((k % 2) == 1);
      if (TOP16 < NSLICE) begin : g_top
        assign topCarry = (strobes.laneLog == 2'd0) ? carryOut[k]  : carryOut[TOP16];
        assign topOvf   = (strobes.laneLog == 2'd0) ? (carryOut[k] ^ carryMsb[k])
                                                    : (carryOut[TOP16] ^ carryMsb[TOP16]);
        assign topSign  = (strobes.laneLog == 2'd0) ? sliceSign[k] : sliceSign[TOP16];
      end else begin : g_topself
        assign topCarry = carryOut[k];
        assign topOvf   = carryOut[k] ^ carryMsb[k];
        assign topSign  = sliceSign[k];
      end

      assign usatHit = strobes.doSub ? !topCarry : topCarry;

      always_comb begin
        satVal = sumS;
        if (strobes.satSigned && topOvf) begin
          if (topSign) satVal = isTop ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
          else         satVal = isTop ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
        end else if (strobes.satUnsigned && usatHit) begin
          satVal = strobes.doSub ? '0 : '1;
        end
      end

      assign nextResult[k*SLICE_W +: SLICE_W] = satVal;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ  <= '0;
      illegalQ <= 1'b0;
    end else if (strobes.load) begin
      resultQ  <= nextResult;
      illegalQ <= strobes.illegal;
    end
  end

  // R5: unsigned clamped byte add never drops below operand A
  assert_usat_add_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.satUnsigned && !strobes.doSub && strobes.laneLog == 2'd0)
      |=> (resultQ[SLICE_W-1:0] >= $past(a[SLICE_W-1:0])));

  // R6: unsigned clamped byte subtract never exceeds operand A
  assert_usat_sub_ceiling_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.satUnsigned && strobes.doSub && strobes.laneLog == 2'd0)
      |=> (resultQ[SLICE_W-1:0] <= $past(a[SLICE_W-1:0])));

  // R4: signed clamped add of two non-negative bytes stays non-negative
  assert_ssat_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.satSigned && !strobes.doSub && strobes.laneLog == 2'd0
      && !a[SLICE_W-1] && !b[SLICE_W-1])
      |=> !resultQ[SLICE_W-1]);

  // R9: held state while no load
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !strobes.load) |=> $stable(resultQ));

endmodule

// File: rtl/simd_addsub_unit.sv
module simd_addsub_unit
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int SLICE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSub,
  input  logic [1:0]        laneSel,
  input  logic [1:0]        arithMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalOp
);

  ctrlStrobesT strobes;

  simd_addsub_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .opSub     (opSub),
    .laneSel   (laneSel),
    .arithMode (arithMode),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  simd_addsub_dp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .a        (opA),
    .b        (opB),
    .resultQ  (result),
    .illegalQ (illegalOp)
  );

  // R7: clamp at 32/64-bit lanes, or the reserved mode, raises the flag
  assert_illegal_width_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ((arithMode != 2'd0 && laneSel[1]) || arithMode == 2'd3)) |=> illegalOp);

endmodule

// File: tb/test_simd_addsub_unit.sv
`timescale 1ns/1ps
module test_simd_addsub_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         opSub = 1'b0;
  logic [1:0]   laneSel = 2'd0;
  logic [1:0]   arithMode = 2'd0;
  logic [255:0] opA = '0;
  logic [255:0] opB = '0;
  logic         outValid;
  logic [255:0] result;
  logic         illegalOp;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  simd_addsub_unit i_simd_addsub_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSub(opSub),
    .laneSel(laneSel), .arithMode(arithMode), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  function automatic logic [255:0] refModel(input logic [255:0] a, input logic [255:0] b,
                                            input logic sub, input logic [1:0] ls,
                                            input logic [1:0] md, output logic ill);
    int w;
    int effMode;
    logic [255:0] res;
    w = 8 << ls;
    ill = (md != 2'd0) && (w > 16 || md == 2'd3);
    effMode = ill ? 0 : int'(md);
    res = '0;
    for (int i = 0; i < 256 / w; i++) begin
      logic signed [66:0] x, y, r, lo, hi;
      x = '0; y = '0;
      for (int j = 0; j < w; j++) begin
        x[j] = a[i*w+j];
        y[j] = b[i*w+j];
      end
      if (effMode == 1) begin
        if (x[w-1]) x = x - (67'sd1 <<< w);
        if (y[w-1]) y = y - (67'sd1 <<< w);
        lo = -(67'sd1 <<< (w-1));
        hi = (67'sd1 <<< (w-1)) - 67'sd1;
      end else begin
        lo = 67'sd0;
        hi = (67'sd1 <<< w) - 67'sd1;
      end
      r = sub ? (x - y) : (x + y);
      if (effMode != 0) begin
        if (r < lo) r = lo;
        if (r > hi) r = hi;
      end
      for (int j = 0; j < w; j++) res[i*w+j] = r[j];
    end
    return res;
  endfunction

  function automatic string tagFor(input logic sub, input logic [1:0] ls, input logic [1:0] md);
    if ((md != 2'd0) && (ls[1] || md == 2'd3)) return "R7";
    if (md == 2'd0) return sub ? "R2" : "R1";
    if (md == 2'd1) return "R4";
    return sub ? "R6" : "R5";
  endfunction

  task automatic nextRand(output logic [255:0] v);
    for (int q = 0; q < 4; q++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      v[q*64 +: 64] = rng;
    end
  endtask

  // Called at a negedge: drive one operation, wait one cycle, compare.
  task automatic runVec(input logic [255:0] a, input logic [255:0] b, input logic sub,
                        input logic [1:0] ls, input logic [1:0] md, input string tag);
    logic [255:0] expR;
    logic expI;
    expR = refModel(a, b, sub, ls, md, expI);
    opA = a; opB = b; opSub = sub; laneSel = ls; arithMode = md; inValid = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== expR || illegalOp !== expI || outValid !== 1'b1) begin
      errors++;
      $display("FAIL %s ls=%0d md=%0d sub=%0d: result=%h ill=%b vld=%b expected %h ill=%b vld=1",
               tag, ls, md, sub, result, illegalOp, outValid, expR, expI);
    end
  endtask

  function automatic logic [255:0] fillLanes(input logic [1:0] ls, input logic [63:0] v);
    logic [255:0] r;
    int w;
    w = 8 << ls;
    r = '0;
    for (int i = 0; i < 256 / w; i++)
      for (int j = 0; j < w; j++) r[i*w+j] = v[j];
    return r;
  endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] ra, rb, held;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (outValid !== 1'b0 || illegalOp !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10 reset: vld=%b ill=%b result=%h expected 0 0 0", outValid, illegalOp, result);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3: lane isolation, all-ones plus one and zero minus one per width
    for (int ls = 0; ls < 4; ls++) begin
      runVec('1, fillLanes(2'(ls), 64'd1), 1'b0, 2'(ls), 2'd0, "R3");
      runVec('0, fillLanes(2'(ls), 64'd1), 1'b1, 2'(ls), 2'd0, "R3");
    end

    // edge values per width and mode: maxS+1, minS-1, ones+1, 0-1
    for (int ls = 0; ls < 4; ls++) begin
      for (int md = 0; md < 3; md++) begin
        logic [63:0] ones, maxS, minS;
        int w;
        w = 8 << ls;
        ones = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        minS = 64'd1 << (w - 1);
        maxS = minS - 64'd1;
        runVec(fillLanes(2'(ls), maxS), fillLanes(2'(ls), 64'd1), 1'b0, 2'(ls), 2'(md),
               tagFor(1'b0, 2'(ls), 2'(md)));
        runVec(fillLanes(2'(ls), minS), fillLanes(2'(ls), 64'd1), 1'b1, 2'(ls), 2'(md),
               tagFor(1'b1, 2'(ls), 2'(md)));
        runVec(fillLanes(2'(ls), ones), fillLanes(2'(ls), 64'd1), 1'b0, 2'(ls), 2'(md),
               tagFor(1'b0, 2'(ls), 2'(md)));
        runVec('0, fillLanes(2'(ls), 64'd1), 1'b1, 2'(ls), 2'(md),
               tagFor(1'b1, 2'(ls), 2'(md)));
      end
    end

    // R1 R2 R4 R5 R6: exhaustive byte-pair sweep in every mode and direction
    for (int md = 0; md < 3; md++) begin
      for (int sb = 0; sb < 2; sb++) begin
        for (int av = 0; av < 256; av++) begin
          for (int g = 0; g < 8; g++) begin
            logic [255:0] bv;
            for (int i = 0; i < 32; i++) bv[i*8 +: 8] = 8'(g*32 + i);
            runVec(fillLanes(2'd0, 64'(av)), bv, sb[0], 2'd0, 2'(md),
                   tagFor(sb[0], 2'd0, 2'(md)));
          end
        end
      end
    end

    // wider lanes and the reserved mode code (R7) with pseudo-random data
    for (int ls = 1; ls < 4; ls++) begin
      for (int md = 0; md < 4; md++) begin
        for (int sb = 0; sb < 2; sb++) begin
          for (int n = 0; n < 200; n++) begin
            nextRand(ra);
            nextRand(rb);
            runVec(ra, rb, sb[0], 2'(ls), 2'(md), tagFor(sb[0], 2'(ls), 2'(md)));
          end
        end
      end
    end
    nextRand(ra);
    nextRand(rb);
    runVec(ra, rb, 1'b0, 2'd0, 2'd3, "R7");

    // R8 R9: idle cycles drop valid and keep result and flag
    held = result;
    inValid = 1'b0;
    opA = ~opA; opB = ~opB; laneSel = 2'd2; arithMode = 2'd0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0) begin
      errors++;
      $display("FAIL R8 idle: vld=%b expected 0", outValid);
    end
    @(negedge clk);
    checks++;
    if (result !== held || illegalOp !== 1'b1) begin
      errors++;
      $display("FAIL R9 hold: result=%h ill=%b expected %h ill=1", result, illegalOp, held);
    end

    // R10: reset during operation
    rstN = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || illegalOp !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R10 reset: vld=%b ill=%b result=%h expected 0 0 0", outValid, illegalOp, result);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule